// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block prepares five asynchronous external interrupt lines for a processor's interrupt controller. Each line is first brought into the clock domain through a chain of flip-flops, two deep by default. Its level is then normalised using a per-line polarity setting, so that every later stage only sees "active" as logic 1. Each line is also set to one of two detection modes. In level mode the request follows the conditioned input. In edge mode a sticky pending bit records each synchronised arrival at the active level.

The block drives three outputs. The request vector goes to the interrupt controller. A per-line acknowledge vector shows whether each conditioned input is active at this moment. A wake signal goes to a power-down controller, which must leave power-down as soon as any request is present. A small register port sets the polarity and the mode, clears pending bits, and reads back the block's state.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset the polarity register reads all ones (every line active-high), the mode register reads all zeros (every line level mode), and no pending bit is set; with all inputs low, irq_req, irq_ack and wake are 0.
- R2: An input change reaches irq_ack exactly two rising clock edges after it is first sampled, and not after one.
- R3: Polarity register (address 0), bit i: 1 means line i is active when high, 0 means active when low; irq_ack[i] is 1 exactly when the synchronised input is at its active level.
- R4: With mode bit i at 0 (level mode), irq_req[i] equals irq_ack[i] with no latching, and falls as soon as the conditioned input goes inactive.
- R5: With mode bit i at 1 (edge mode, mode register at address 1), a synchronised transition into the active level sets pending bit i one clock after irq_ack[i] rises. The bit then drives irq_req[i] and stays set after the input goes inactive.
- R6: Writing address 2 clears each pending bit whose data bit is 1 and leaves bits written as 0 alone; if a new edge arrives in the same cycle as the clear, the bit stays set.
- R7: A write that changes line i's polarity bit or mode bit clears pending bit i. A polarity change alone never produces an edge, and a write that leaves the bit's value unchanged does not clear the pending bit.
- R8: wake is 1 exactly when any bit of irq_req is 1.
- R9: Reading returns the polarity bits at address 0, the mode bits at address 1, the pending bits at address 2 and the irq_ack vector at address 3, with bit i belonging to line i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 5 | Asynchronous external interrupt lines |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select for write and read |
| cfg_wdata | input | 5 | Write data, one bit per line |
| cfg_rdata | output | 5 | Read data for cfg_addr (combinational) |
| irq_req | output | 5 | Request vector to the interrupt controller |
| irq_ack | output | 5 | Per-line active indication of the conditioned input |
| wake | output | 1 | Wake request to the power-down controller |

## Verification
The hardest case to reach is a new edge landing in the same clock edge as a write-one-to-clear of the same pending bit. The bench reaches it by counting synchroniser stages: it raises the input, waits two falling edges, and then holds the clear write across the third rising edge, which is the edge that sets the pending bit. A second case that is hard to reach is a polarity flip on a line whose input is steady. The bench makes this flip while the line has a pending bit set and checks that the bit clears and that no new edge appears.

// File: rtl/ext_irq_pkg.sv
// Package: shared register selector for the external interrupt conditioner.
// Assumes a two-bit register address.
package ext_irq_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_POL  = 2'd0,
        REG_MODE = 2'd1,
        REG_PEND = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ext_irq_sync.sv
// Module: multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is unrelated to the others (no bus coherency needed)
// and STAGES >= 2.
module ext_irq_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the sampled input through the flip-flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_line.sv
// Module: one interrupt line after synchronisation. It normalises the
// polarity, detects edges and holds the pending bit.
// Assumes raw is already synchronous. A configuration change wins over
// a set, and a set wins over a write-one-to-clear.
module ext_irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol_high,
    input  logic edge_mode,
    input  logic cfg_chg,
    input  logic w1c,
    output logic active,
    output logic pend,
    output logic req
);
    logic raw_prev;
    logic edge_hit;

    // Normalise: 1 means the line is at its programmed active level.
    assign active   = ~(raw ^ pol_high);
    // An edge is a raw transition that lands on the active level.
    assign edge_hit = active & (raw != raw_prev);

    // Remember the previous synchronised raw level.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_prev <= 1'b0;
        else        raw_prev <= raw;
    end

    // Pending bit: config change clears, edge sets, then W1C clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                     pend <= 1'b0;
        else if (cfg_chg)               pend <= 1'b0;
        else if (edge_mode && edge_hit) pend <= 1'b1;
        else if (w1c)                   pend <= 1'b0;
    end

    assign req = edge_mode ? pend : active;
endmodule

// File: rtl/ext_irq_regs.sv
// Module: configuration registers, change detection and read multiplexer.
// Assumes a single-cycle write strobe; read data is combinational.
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int          N        = 5,
    parameter logic [N-1:0] POL_RST  = '1,
    parameter logic [N-1:0] MODE_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [N-1:0]      cfg_wdata,
    input  logic [N-1:0]      pend,
    input  logic [N-1:0]      ack,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      mode_q,
    output logic [N-1:0]      cfg_chg,
    output logic [N-1:0]      w1c,
    output logic [N-1:0]      cfg_rdata
);
    reg_sel_e sel;
    logic     wr_pol;
    logic     wr_mode;

    assign sel     = reg_sel_e'(cfg_addr);
    assign wr_pol  = cfg_wr && (sel == REG_POL);
    assign wr_mode = cfg_wr && (sel == REG_MODE);

    // Store polarity and mode settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= POL_RST;
            mode_q <= MODE_RST;
        end else begin
            if (wr_pol)  pol_q  <= cfg_wdata;
            if (wr_mode) mode_q <= cfg_wdata;
        end
    end

    // Flag lines whose configuration value actually changes on this write.
    always_comb begin
        cfg_chg = '0;
        if (wr_pol)  cfg_chg = cfg_chg | (cfg_wdata ^ pol_q);
        if (wr_mode) cfg_chg = cfg_chg | (cfg_wdata ^ mode_q);
    end

    // Write-one-to-clear request for the pending bits.
    assign w1c = (cfg_wr && (sel == REG_PEND)) ? cfg_wdata : '0;

    // Read-back multiplexer.
    always_comb begin
        unique case (sel)
            REG_POL:  cfg_rdata = pol_q;
            REG_MODE: cfg_rdata = mode_q;
            REG_PEND: cfg_rdata = pend;
            default:  cfg_rdata = ack;
        endcase
    end
endmodule

// File: rtl/ext_irq_cond.sv
// Module: top of the external interrupt input conditioner. It synchronises
// the lines, conditions each one and drives the request, acknowledge and
// wake outputs. Assumes a single clock with a synchronous active-low reset.
module ext_irq_cond
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [NUM_LINES-1:0] cfg_wdata,
    output logic [NUM_LINES-1:0] cfg_rdata,
    output logic [NUM_LINES-1:0] irq_req,
    output logic [NUM_LINES-1:0] irq_ack,
    output logic                 wake
);
    logic [NUM_LINES-1:0] raw_sync;
    logic [NUM_LINES-1:0] pol_q;
    logic [NUM_LINES-1:0] mode_q;
    logic [NUM_LINES-1:0] cfg_chg;
    logic [NUM_LINES-1:0] w1c;
    logic [NUM_LINES-1:0] pend;

    ext_irq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (raw_sync)
    );

    ext_irq_regs #(.N(NUM_LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pend      (pend),
        .ack       (irq_ack),
        .pol_q     (pol_q),
        .mode_q    (mode_q),
        .cfg_chg   (cfg_chg),
        .w1c       (w1c),
        .cfg_rdata (cfg_rdata)
    );

    // One conditioning slice per line.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        ext_irq_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw       (raw_sync[g]),
            .pol_high  (pol_q[g]),
            .edge_mode (mode_q[g]),
            .cfg_chg   (cfg_chg[g]),
            .w1c       (w1c[g]),
            .active    (irq_ack[g]),
            .pend      (pend[g]),
            .req       (irq_req[g])
        );
    end

    assign wake = |irq_req;
endmodule

// File: rtl/ext_irq_cond_chk.sv
// Module: assertion checker for ext_irq_cond, attached through bind.
// Assumes it sees the top's ports plus the stored polarity and mode bits.
module ext_irq_cond_chk
    import ext_irq_pkg::*;
#(
    parameter int N = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      irq_in,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [N-1:0]      cfg_wdata,
    input logic [N-1:0]      irq_req,
    input logic [N-1:0]      irq_ack,
    input logic              wake,
    input logic [N-1:0]      cfg_pol,
    input logic [N-1:0]      cfg_mode
);
    logic [1:0] cyc;

    // Count cycles since reset, saturating, to guard the two-deep $past.
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R2 and R3: the acknowledge is the input from two edges ago at its programmed level.
    a_r3_ack_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (irq_ack == ~($past(irq_in, 2) ^ cfg_pol)));

    // R4: a level-mode line's request equals its acknowledge.
    a_r4_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req & ~cfg_mode) == (irq_ack & ~cfg_mode)));

    // R5: an edge-mode request stays set while no register write occurs.
    a_r5_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> (($past(irq_req) & ~irq_req & cfg_mode) == '0));

    // R7: a changed mode bit leaves no pending request on that line.
    a_r7_mode_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == REG_MODE) |=>
        ((irq_req & cfg_mode & ($past(cfg_wdata) ^ $past(cfg_mode))) == '0));

    // R8: any active level-mode line raises wake.
    a_r8_wake_on_level: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_ack & ~cfg_mode)) |-> wake);
endmodule

bind ext_irq_cond ext_irq_cond_chk #(.N(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .irq_req   (irq_req),
    .irq_ack   (irq_ack),
    .wake      (wake),
    .cfg_pol   (pol_q),
    .cfg_mode  (mode_q)
);

// File: tb/ext_irq_cond_tb_top.sv
// Bench: directed tests for ext_irq_cond, one task per scenario.
module ext_irq_cond_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] irq_in = '0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [4:0] cfg_wdata = '0;
    logic [4:0] cfg_rdata;
    logic [4:0] irq_req;
    logic [4:0] irq_ack;
    logic       wake;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    ext_irq_cond dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .irq_req   (irq_req),
        .irq_ack   (irq_ack),
        .wake      (wake)
    );

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [4:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [4:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic t_reset();
        logic [4:0] d;
        nclk(3);
        rst_n = 1'b1;
        nclk(1);
        chk("R1 req", irq_req, 5'b0);
        chk("R1 ack", irq_ack, 5'b0);
        chk("R1 wake", {4'b0, wake}, 5'b0);
        rd_reg(2'd0, d); chk("R1 pol", d, 5'b11111);
        rd_reg(2'd1, d); chk("R1 mode", d, 5'b00000);
        rd_reg(2'd2, d); chk("R1 pend", d, 5'b00000);
    endtask

    task automatic t_sync_latency();
        @(negedge clk); irq_in[0] = 1'b1;
        nclk(1); chk("R2 ack after one edge", irq_ack, 5'b00000);
        nclk(1); chk("R2 ack after two edges", irq_ack, 5'b00001);
        irq_in[0] = 1'b0;
        nclk(2); chk("R2 ack drops", irq_ack, 5'b00000);
    endtask

    task automatic t_polarity();
        wr_reg(2'd0, 5'b11101);
        chk("R3 active-low line idle low", irq_ack, 5'b00010);
        irq_in[1] = 1'b1;
        nclk(2); chk("R3 active-low line driven high", irq_ack, 5'b00000);
        wr_reg(2'd0, 5'b11111);
        irq_in[1] = 1'b0;
        nclk(2); chk("R3 restored", irq_ack, 5'b00000);
    endtask

    task automatic t_level();
        irq_in[2] = 1'b1;
        nclk(2);
        chk("R4 level req", irq_req, 5'b00100);
        chk("R8 wake high", {4'b0, wake}, 5'b00001);
        irq_in[2] = 1'b0;
        nclk(2);
        chk("R4 level drops", irq_req, 5'b00000);
        chk("R8 wake low", {4'b0, wake}, 5'b00000);
    endtask

    task automatic t_edge();
        logic [4:0] d;
        wr_reg(2'd1, 5'b01000);
        irq_in[3] = 1'b1;
        nclk(2);
        chk("R5 ack before pending", irq_ack, 5'b01000);
        chk("R5 req not yet", irq_req, 5'b00000);
        nclk(1);
        chk("R5 pending set", irq_req, 5'b01000);
        irq_in[3] = 1'b0;
        nclk(3);
        chk("R5 pending held", irq_req, 5'b01000);
        chk("R8 wake from pending", {4'b0, wake}, 5'b00001);
        rd_reg(2'd2, d); chk("R9 pend readback", d, 5'b01000);
    endtask

    task automatic t_w1c();
        wr_reg(2'd2, 5'b10111);
        nclk(1); chk("R6 zero bit keeps pending", irq_req, 5'b01000);
        wr_reg(2'd2, 5'b01000);
        chk("R6 one bit clears", irq_req, 5'b00000);
        chk("R8 wake after clear", {4'b0, wake}, 5'b00000);
    endtask

    task automatic t_collision();
        @(negedge clk); irq_in[3] = 1'b1;
        nclk(2);
        cfg_wr = 1'b1; cfg_addr = 2'd2; cfg_wdata = 5'b01000;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
        chk("R6 set wins over clear", irq_req, 5'b01000);
    endtask

    task automatic t_cfg_change();
        logic [4:0] d;
        // line 3 pending, input high; flip polarity to active-low
        wr_reg(2'd0, 5'b10111);
        chk("R7 polarity change clears", irq_req, 5'b00000);
        nclk(3);
        chk("R7 no edge from polarity flip", irq_req, 5'b00000);
        irq_in[3] = 1'b0;
        nclk(3);
        chk("R5 active-low edge sets", irq_req, 5'b01000);
        wr_reg(2'd1, 5'b01000);
        chk("R7 same-value write keeps", irq_req, 5'b01000);
        wr_reg(2'd1, 5'b00000);
        rd_reg(2'd2, d); chk("R7 mode change clears pend", d, 5'b00000);
        chk("R4 level follows after change", irq_req, 5'b01000);
        rd_reg(2'd3, d); chk("R9 ack readback", d, 5'b01000);
        rd_reg(2'd0, d); chk("R9 pol readback", d, 5'b10111);
        wr_reg(2'd0, 5'b11111);
        nclk(2);
        chk("R3 idle after restore", irq_ack, 5'b00000);
    endtask

    initial begin
        t_reset();
        t_sync_latency();
        t_polarity();
        t_level();
        t_edge();
        t_w1c();
        t_collision();
        t_cfg_change();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule